// File: doc/BRIEF.md
# DRAM DLL-Off Power-Up Sequencer

This block sits on the controller side of a graphics DRAM interface. It brings the memory device out of power-up with the device DLL switched off. This mode is meant for slow clocks, from 100 MHz to 350 MHz.

The block starts when an asynchronous power-good input rises. At that point supply and clock are assumed stable. The block first holds the device in reset for a long settling wait. It then releases the device reset and, a few cycles later, raises clock enable. After a long deselect gap it issues this command stream:

1. precharge-all
2. extended mode set (DLL disabled)
3. mode set
4. precharge-all
5. auto-refresh
6. auto-refresh

Each command is followed by its minimum gap. When the last wait runs out, a done flag rises and stays high. Normal traffic may then begin.

All waits are parameters counted in clock cycles, and a single down-counter times every step. Power-good is synchronised through two flip-flops. If power-good drops, the block falls back to its initial state. It runs the whole sequence again when power-good returns.

Top module: `dlloff_init_seq`

## Requirements
- R1: While `rst` is high, or within three clock edges after power-good goes low, the outputs are: `mem_rst_n`=0, `mem_cke`=0, deselect on the command pins, `init_done`=0.
- R2: `mem_rst_n` rises exactly PWR_CYC+3 rising edges after power-good rises. The three extra edges are two synchroniser stages and one output register. PWR_CYC stands for the 200 µs settling time.
- R3: On every cycle with `mem_cs_n`=1, `mem_addr` and `mem_ba` are zero. This holds the address still around the release of device reset.
- R4: `mem_cke` rises exactly ATH_CYC cycles after `mem_rst_n` rises, and is never high while `mem_rst_n` is low.
- R5: Commands are encoded on {cs_n,ras_n,cas_n,we_n}: precharge-all 0010, mode set 0000, auto-refresh 0001, deselect 1111. The only non-deselect cycles are, in this order: precharge-all, mode set with bank 1 (extended), mode set with bank 0, precharge-all, auto-refresh, auto-refresh.
- R6: Timing between events is exact:
  - from `mem_cke` rising to the first precharge-all: LONG_GAP cycles;
  - then to the extended mode set: TRP;
  - then to the mode set: TMRD;
  - then to the second precharge-all: TMRD;
  - then to the first auto-refresh: TRP;
  - then to the second auto-refresh: TRFC.
- R7: The extended mode set drives `mem_ba`=1 and `mem_addr`=EMR_VAL with bit 0 forced to 1, which disables the DLL. The mode set drives `mem_ba`=0 and `mem_addr`=MR_VAL. Precharge-all drives `mem_ba`=0 and only address bit PALL_BIT high.
- R8: `init_done` rises exactly max(TRFC, SHORT_GAP) cycles after the second auto-refresh. It then stays high with deselect on the command pins for as long as power-good stays high.
- R9: When power-good drops in the middle of the sequence and later returns, the whole sequence restarts from the settling wait. The full event order and timing are repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, 100–350 MHz |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good | input | 1 | Asynchronous supply/clock-stable indication |
| mem_rst_n | output | 1 | Device reset, active low |
| mem_cke | output | 1 | Device clock enable |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ba | output | BA_W | Bank address |
| mem_addr | output | ADDR_W | Address bus |
| init_done | output | 1 | Initialisation complete, sticky |

## Verification
The embedded properties assume two things about the inputs:
- `rst` is high at the first clock edge;
- power-good changes slowly compared with the clock, so each level lasts several cycles.

The bench moves power-good only on falling clock edges. It holds each level for many more cycles than the synchroniser depth, so the restart properties always observe a clean drop followed by a clean return. One power-good drop is placed just after clock enable rises, so an abort lands in the long gap before any command has been issued.

// File: rtl/dlloff_init_pkg.sv
package dlloff_init_pkg;

  typedef enum logic [3:0] {
    ST_PWR, ST_RST, ST_GAP, ST_PA1, ST_EMR, ST_MRS, ST_PA2, ST_ARF1, ST_ARF2, ST_DONE
  } step_e;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_DES  = 4'b1111,
    CMD_PALL = 4'b0010,
    CMD_MRS  = 4'b0000,
    CMD_REF  = 4'b0001
  } cmd_e;

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dlloff_pg_sync.sv
module dlloff_pg_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= async_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-2:0], async_in};
      end
    end
  endgenerate

  assign sync_out = sh[STAGES-1];
endmodule

// File: rtl/dlloff_step_seq.sv
module dlloff_step_seq
  import dlloff_init_pkg::*;
#(
  parameter int unsigned PWR_CYC   = 70000,
  parameter int unsigned ATH_CYC   = 4,
  parameter int unsigned LONG_GAP  = 700,
  parameter int unsigned TRP       = 8,
  parameter int unsigned TMRD      = 6,
  parameter int unsigned TRFC      = 40,
  parameter int unsigned SHORT_GAP = 300
) (
  input  logic  clk,
  input  logic  clr,
  output step_e step_o,
  output logic  first_o
);
  localparam int unsigned LAST_LEN = max2(TRFC, SHORT_GAP);
  localparam int unsigned MAX_LEN  = max2(max2(max2(PWR_CYC, LONG_GAP), max2(TRP, TMRD)),
                                          max2(LAST_LEN, ATH_CYC));
  localparam int unsigned CNT_W    = $clog2(MAX_LEN + 1);

  step_e            step;
  logic [CNT_W-1:0] cnt;
  logic             first;
  logic [3:0]       nxt_raw;
  step_e            nxt;

  function automatic logic [CNT_W-1:0] len_m1(step_e s);
    case (s)
      ST_PWR:  return CNT_W'(PWR_CYC - 1);
      ST_RST:  return CNT_W'(ATH_CYC - 1);
      ST_GAP:  return CNT_W'(LONG_GAP - 1);
      ST_PA1:  return CNT_W'(TRP - 1);
      ST_EMR:  return CNT_W'(TMRD - 1);
      ST_MRS:  return CNT_W'(TMRD - 1);
      ST_PA2:  return CNT_W'(TRP - 1);
      ST_ARF1: return CNT_W'(TRFC - 1);
      ST_ARF2: return CNT_W'(LAST_LEN - 1);
      default: return '0;
    endcase
  endfunction

  assign nxt_raw = 4'(step) + 4'd1;
  assign nxt     = step_e'(nxt_raw);

  always_ff @(posedge clk) begin
    if (clr) begin
      step  <= ST_PWR;
      cnt   <= len_m1(ST_PWR);
      first <= 1'b1;
    end else if (step != ST_DONE) begin
      if (cnt == '0) begin
        step  <= nxt;
        cnt   <= len_m1(nxt);
        first <= 1'b1;
      end else begin
        cnt   <= cnt - 1'b1;
        first <= 1'b0;
      end
    end
  end

  assign step_o  = step;
  assign first_o = first;

  // R5: steps only ever advance by one position, never skip or go back
  a_r5_step_order: assert property (@(posedge clk) disable iff (clr)
    (!$past(clr) && step != $past(step)) |-> (4'(step) == 4'($past(step)) + 4'd1));

  // R8: the final step is terminal while power is good
  a_r8_done_terminal: assert property (@(posedge clk) disable iff (clr)
    (step == ST_DONE) |=> (step == ST_DONE));

  initial begin
    assert (PWR_CYC >= 1 && ATH_CYC >= 1 && LONG_GAP >= 1 && TRP >= 1 &&
            TMRD >= 1 && TRFC >= 1);
  end
endmodule

// File: rtl/dlloff_cmd_out.sv
module dlloff_cmd_out
  import dlloff_init_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned BA_W     = 3,
  parameter int unsigned PALL_BIT = 8,
  parameter logic [ADDR_W-1:0] MR_VAL  = '0,
  parameter logic [ADDR_W-1:0] EMR_VAL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  step_e             step_i,
  input  logic              first_i,
  output logic              rst_n_q,
  output logic              cke_q,
  output logic [3:0]        cmd_q,
  output logic [BA_W-1:0]   ba_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              done_q
);
  logic              rst_n_d, cke_d, done_d;
  logic [3:0]        cmd_d;
  logic [BA_W-1:0]   ba_d;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    rst_n_d = (step_i != ST_PWR);
    cke_d   = (step_i != ST_PWR) && (step_i != ST_RST);
    done_d  = (step_i == ST_DONE);
    cmd_d   = 4'(CMD_DES);
    ba_d    = '0;
    addr_d  = '0;
    if (first_i) begin
      case (step_i)
        ST_PA1, ST_PA2: begin
          cmd_d            = 4'(CMD_PALL);
          addr_d[PALL_BIT] = 1'b1;
        end
        ST_EMR: begin
          cmd_d  = 4'(CMD_MRS);
          ba_d   = BA_W'(1);
          addr_d = EMR_VAL | ADDR_W'(1);
        end
        ST_MRS: begin
          cmd_d  = 4'(CMD_MRS);
          addr_d = MR_VAL;
        end
        ST_ARF1, ST_ARF2: cmd_d = 4'(CMD_REF);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      rst_n_q <= 1'b0;
      cke_q   <= 1'b0;
      cmd_q   <= 4'(CMD_DES);
      ba_q    <= '0;
      addr_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      rst_n_q <= rst_n_d;
      cke_q   <= cke_d;
      cmd_q   <= cmd_d;
      ba_q    <= ba_d;
      addr_q  <= addr_d;
      done_q  <= done_d;
    end
  end

  // R1: a clear cycle leaves the device held and idle
  a_r1_clear_idle: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!rst_n_q && !cke_q && cmd_q == 4'(CMD_DES) && !done_q));

  // R3: address and bank quiet on every deselect cycle
  a_r3_addr_quiet: assert property (@(posedge clk) disable iff (rst)
    cmd_q[3] |-> (addr_q == '0 && ba_q == '0));

  // R4: clock enable never ahead of reset release
  a_r4_cke_after_rst: assert property (@(posedge clk) disable iff (rst)
    cke_q |-> rst_n_q);

  // R7: extended mode set always disables the DLL
  a_r7_emr_dll_off: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == 4'(CMD_MRS) && ba_q == BA_W'(1)) |-> addr_q[0]);

  // R8: done is sticky and idle while power is good
  a_r8_done_hold: assert property (@(posedge clk) disable iff (clr)
    done_q |=> (done_q && cmd_q == 4'(CMD_DES)));
endmodule

// File: rtl/dlloff_init_seq.sv
module dlloff_init_seq
  import dlloff_init_pkg::*;
#(
  parameter int unsigned PWR_CYC   = 70000,
  parameter int unsigned ATH_CYC   = 4,
  parameter int unsigned LONG_GAP  = 700,
  parameter int unsigned TRP       = 8,
  parameter int unsigned TMRD      = 6,
  parameter int unsigned TRFC      = 40,
  parameter int unsigned SHORT_GAP = 300,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned BA_W      = 3,
  parameter int unsigned PALL_BIT  = 8,
  parameter int unsigned SYNC_STG  = 2,
  parameter logic [ADDR_W-1:0] MR_VAL  = 12'h0A5,
  parameter logic [ADDR_W-1:0] EMR_VAL = 12'h040
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_good,
  output logic              mem_rst_n,
  output logic              mem_cke,
  output logic              mem_cs_n,
  output logic              mem_ras_n,
  output logic              mem_cas_n,
  output logic              mem_we_n,
  output logic [BA_W-1:0]   mem_ba,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              init_done
);
  logic       pg_ok, clr, first;
  step_e      step;
  logic [3:0] cmd;

  dlloff_pg_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst(rst), .async_in(pwr_good), .sync_out(pg_ok)
  );

  assign clr = rst | ~pg_ok;

  dlloff_step_seq #(
    .PWR_CYC(PWR_CYC), .ATH_CYC(ATH_CYC), .LONG_GAP(LONG_GAP), .TRP(TRP),
    .TMRD(TMRD), .TRFC(TRFC), .SHORT_GAP(SHORT_GAP)
  ) u_seq (
    .clk(clk), .clr(clr), .step_o(step), .first_o(first)
  );

  dlloff_cmd_out #(
    .ADDR_W(ADDR_W), .BA_W(BA_W), .PALL_BIT(PALL_BIT),
    .MR_VAL(MR_VAL), .EMR_VAL(EMR_VAL)
  ) u_out (
    .clk(clk), .rst(rst), .clr(clr), .step_i(step), .first_i(first),
    .rst_n_q(mem_rst_n), .cke_q(mem_cke), .cmd_q(cmd), .ba_q(mem_ba),
    .addr_q(mem_addr), .done_q(init_done)
  );

  assign {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} = cmd;
endmodule

// File: tb/tb_dlloff_init_seq.sv
module tb_dlloff_init_seq;
  localparam int PWR = 50, ATH = 3, LONG = 20, TRP = 4, TMRD = 3, TRFC = 7, SHORT = 12;
  localparam int LAST = (TRFC > SHORT) ? TRFC : SHORT;
  localparam logic [11:0] MR = 12'h0A5, EMR = 12'h040;

  logic clk = 1'b0, rst = 1'b1, pg = 1'b0;
  logic mem_rst_n, mem_cke, cs_n, ras_n, cas_n, we_n, done;
  logic [2:0]  ba;
  logic [11:0] addr;

  always #2.5 clk = ~clk;

  dlloff_init_seq #(
    .PWR_CYC(PWR), .ATH_CYC(ATH), .LONG_GAP(LONG), .TRP(TRP), .TMRD(TMRD),
    .TRFC(TRFC), .SHORT_GAP(SHORT), .MR_VAL(MR), .EMR_VAL(EMR)
  ) dut (
    .clk(clk), .rst(rst), .pwr_good(pg), .mem_rst_n(mem_rst_n), .mem_cke(mem_cke),
    .mem_cs_n(cs_n), .mem_ras_n(ras_n), .mem_cas_n(cas_n), .mem_we_n(we_n),
    .mem_ba(ba), .mem_addr(addr), .init_done(done)
  );

  typedef struct {
    int kind;            // 0 rst_n rise, 1 cke rise, 2 command, 3 done rise
    logic [3:0]  cmd;
    logic [2:0]  ba;
    logic [11:0] addr;
    int gap;
  } ev_t;

  ev_t exp_q[$];
  int  n_run = 0, n_fail = 0, cyc = 0, last_cyc = 0;
  logic p_rstn = 0, p_cke = 0, p_done = 0, quiet_bad = 0, hold_bad = 0, finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic push(int k, logic [3:0] c, logic [2:0] b, logic [11:0] a, int g);
    ev_t e;
    e.kind = k; e.cmd = c; e.ba = b; e.addr = a; e.gap = g;
    exp_q.push_back(e);
  endtask

  task automatic push_seq();
    push(0, 4'hF, 0, 0, PWR + 3);                // R2
    push(1, 4'hF, 0, 0, ATH);                    // R4
    push(2, 4'b0010, 0, 12'h100, LONG);          // R5 R6 R7
    push(2, 4'b0000, 1, EMR | 12'h001, TRP);
    push(2, 4'b0000, 0, MR, TMRD);
    push(2, 4'b0010, 0, 12'h100, TMRD);
    push(2, 4'b0001, 0, 0, TRP);
    push(2, 4'b0001, 0, 0, TRFC);
    push(3, 4'hF, 0, 0, LAST);                   // R8
  endtask

  task automatic got_ev(int k, logic [3:0] c, logic [2:0] b, logic [11:0] a);
    ev_t e;
    int g;
    g = cyc - last_cyc;
    last_cyc = cyc;
    n_run++;
    if (exp_q.size() == 0) begin
      n_fail++;
      $display("FAIL R5 unexpected event kind=%0d cmd=%b (expected none)", k, c);
      return;
    end
    e = exp_q.pop_front();
    if (e.kind != k || e.cmd != c) begin
      n_fail++;
      $display("FAIL R5 event kind/cmd %0d/%b, expected %0d/%b", k, c, e.kind, e.cmd);
    end else if (e.ba != b || e.addr != a) begin
      n_fail++;
      $display("FAIL R7 ba/addr %0d/%h, expected %0d/%h", b, a, e.ba, e.addr);
    end else if (e.gap != g) begin
      n_fail++;
      $display("FAIL %s gap kind %0d: %0d, expected %0d",
               k == 0 ? "R2" : k == 1 ? "R4" : k == 3 ? "R8" : "R6", k, g, e.gap);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (cs_n && (addr != 0 || ba != 0)) quiet_bad = 1;          // R3
      if (mem_cke && !mem_rst_n) hold_bad = 1;                    // R4
      if (p_done && pg && (!done || !cs_n)) hold_bad = 1;         // R8
      if (mem_rst_n && !p_rstn) got_ev(0, 4'hF, 0, 0);
      if (mem_cke && !p_cke) got_ev(1, 4'hF, 0, 0);
      if (!cs_n) got_ev(2, {cs_n, ras_n, cas_n, we_n}, ba, addr);
      if (done && !p_done) got_ev(3, 4'hF, 0, 0);
    end
    p_rstn = mem_rst_n; p_cke = mem_cke; p_done = done;
  end

  task automatic check(bit ok, string req, string what, int act, int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic check_idle(string req);
    check(!mem_rst_n && !mem_cke && cs_n && ras_n && cas_n && we_n && !done, req,
          "idle outputs {rst_n,cke,cs_n,done}", {mem_rst_n, mem_cke, cs_n, done}, 4'b0010);
  endtask

  task automatic power_up();
    @(negedge clk);
    pg = 1'b1;
    last_cyc = cyc;
  endtask

  task automatic power_down();
    @(negedge clk);
    pg = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    check_idle("R1");
    rst = 1'b0;
    repeat (5) @(negedge clk);
    check_idle("R1");

    // full sequence
    push_seq();
    power_up();
    wait (done);
    repeat (40) @(negedge clk);
    check(done && cs_n, "R8", "done sticky", done, 1);
    check(exp_q.size() == 0, "R5", "events left", exp_q.size(), 0);

    // power loss after completion
    power_down();
    check_idle("R9");

    // abort during the long gap
    push_seq();
    power_up();
    wait (mem_cke);
    repeat (5) @(negedge clk);
    power_down();
    check_idle("R9");
    check(exp_q.size() == 7, "R9", "events seen before abort", 9 - exp_q.size(), 2);
    exp_q.delete();
    repeat (10) @(negedge clk);

    // restart runs the full sequence again
    push_seq();
    power_up();
    wait (done);
    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R9", "restart events left", exp_q.size(), 0);
    check(!quiet_bad, "R3", "address quiet on deselect", quiet_bad, 0);
    check(!hold_bad, "R4", "cke/done hold rules", hold_bad, 0);

    // synchronous reset during done
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check_idle("R1");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: timeout, got no finish expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule